// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing half of a 256-byte serial EEPROM. It watches an oversampled two-wire clock and data pair, recognises the start and stop conditions, decodes the addressing byte, and keeps a persistent word pointer that read and write operations share. It drives only a pull-low enable for the data line, which the pad turns into an open-drain output.

Write data is not stored here. Each accepted data byte goes out on a one-cycle write strobe with its target address to a separate page-buffer and commit block, and the stop condition that closes a write becomes a one-cycle commit pulse. While that block reports an internal write cycle through its busy input, the controller gives no acknowledge at all. A master therefore polls for the end of programming by sending addressing bytes until one is acknowledged. Reads fetch bytes through a combinational read port on the array and shift them out MSB first.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling data line while the synchronised clock is high is a start; it abandons any transfer, releases the data line, and begins receiving an addressing byte. A rising data line while the clock is high is a stop; it releases the data line and returns the block to idle.
- R2: The addressing byte arrives MSB first. Bits 7:4 must equal 1010. Bits 3:1 are ignored. Bit 0 selects the direction, with 1 for read and 0 for write. A matching byte is acknowledged by pulling data low during the ninth clock.
- R3: An addressing byte with bits 7:4 other than 1010 is not acknowledged. The block then drives nothing and issues no write strobe until the next start.
- R4: While busy_in is high at the end of a byte, no acknowledge of any kind is given. This covers the addressing, word-address and data bytes.
- R5: After an acknowledged write addressing byte, the next byte is loaded into the word pointer. Each later data byte is acknowledged and presented for one cycle on wr_valid, with wr_addr equal to the pointer and wr_data equal to the byte.
- R6: During a write, the pointer advances in bits 2:0 only and wraps within its 8-byte page, while bits 7:3 stay fixed. Extra bytes therefore overwrite earlier ones in the page.
- R7: A stop that follows at least one accepted data byte produces exactly one single-cycle commit_pulse. A stop after an address-only write or after a read produces none.
- R8: On an acknowledged read addressing byte, the byte at the pointer is shifted out MSB first, one bit per clock low phase, and the pointer advances by one.
- R9: If the master acknowledges a read byte, the next sequential byte follows. If it does not, the data line is released and stays released until the next start.
- R10: The pointer persists across transfers. A current-address read returns the location after the last one accessed, and a word-address-only write followed by a repeated start and a read returns the addressed byte.
- R11: During sequential reads, the pointer wraps from 255 to 0.
- R12: After reset, sda_oe and wr_valid and commit_pulse are low, and the pointer (rd_addr) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| busy_in | input | 1 | Internal write cycle in progress |
| rd_addr | output | 8 | Word pointer, used as the array read address |
| rd_data | input | 8 | Array byte at rd_addr |
| wr_valid | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr | output | 8 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit_pulse | output | 1 | One-cycle request to program the page |

## Verification
The bound checker enforces the following on every cycle: an acknowledge never starts while busy was reported, a write strobe always coincides with an acknowledge, the data line is free right after any start or stop, nothing is driven while the block ignores a foreign byte, and a commit is always a single cycle directly after a stop. Only the bench scenarios can show the values that cross the bus: which byte a current-address or random read returns, the page-wrap order of overwritten bytes, the 255-to-0 rollover, acknowledge polling ending once busy clears, and recovery from a start in the middle of a byte.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

   localparam int BYTE_W = 8;
   localparam logic [3:0] DEV_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_CTRL,
      ST_RX_ADDR,
      ST_RX_DATA,
      ST_ACK,
      ST_TX,
      ST_RD_ACK,
      ST_IGNORE
   } link_st_e;

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_s;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              page_inc,
   input  logic              lin_inc,
   output logic [ADDR_W-1:0] ptr
);

   logic [ADDR_W-1:0] lin_next;
   logic [ADDR_W-1:0] page_next;

   assign lin_next = ptr + ADDR_W'(1);

   generate
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign page_next = lin_next;
      end else begin : g_paged
         logic [PAGE_W-1:0] lo_next;
         assign lo_next   = ptr[PAGE_W-1:0] + PAGE_W'(1);
         assign page_next = {ptr[ADDR_W-1:PAGE_W], lo_next};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (page_inc) begin
         ptr <= page_next;
      end else if (lin_inc) begin
         ptr <= lin_next;
      end
   end

endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
   import tw_eeprom_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              busy,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              ack_drv,
   output logic              tx_drv,
   output logic              ptr_load,
   output logic [ADDR_W-1:0] ptr_load_val,
   output logic              ptr_page_inc,
   output logic              ptr_lin_inc,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              commit_pulse,
   output link_st_e          st
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   link_st_e          nxt;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              mack;
   logic              wr_seen;
   logic              byte_done;
   logic              code_ok;
   logic              tx_load;

   always_comb begin
      byte_done    = scl_fall && (cnt == LAST_BIT);
      code_ok      = (sh[BYTE_W-1:BYTE_W-4] == DEV_CODE) && !busy;
      tx_load      = scl_fall && (((st == ST_ACK) && (nxt == ST_TX)) ||
                                  ((st == ST_RD_ACK) && mack));
      ptr_load     = (st == ST_RX_ADDR) && byte_done && !busy;
      ptr_load_val = sh[ADDR_W-1:0];
      ptr_page_inc = (st == ST_RX_DATA) && byte_done && !busy;
      ptr_lin_inc  = tx_load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         nxt          <= ST_IDLE;
         cnt          <= '0;
         sh           <= '0;
         mack         <= 1'b0;
         ack_drv      <= 1'b0;
         tx_drv       <= 1'b0;
         wr_valid     <= 1'b0;
         wr_addr      <= '0;
         wr_data      <= '0;
         wr_seen      <= 1'b0;
         commit_pulse <= 1'b0;
      end else begin
         wr_valid     <= 1'b0;
         commit_pulse <= 1'b0;
         if (start_det) begin
            st      <= ST_RX_CTRL;
            cnt     <= '0;
            ack_drv <= 1'b0;
            tx_drv  <= 1'b0;
         end else if (stop_det) begin
            st           <= ST_IDLE;
            ack_drv      <= 1'b0;
            tx_drv       <= 1'b0;
            commit_pulse <= wr_seen;
            wr_seen      <= 1'b0;
         end else begin
            case (st)
               ST_RX_CTRL, ST_RX_ADDR, ST_RX_DATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + CNT_W'(1);
                  end else if (byte_done) begin
                     if (st == ST_RX_CTRL) begin
                        if (code_ok) begin
                           ack_drv <= 1'b1;
                           st      <= ST_ACK;
                           nxt     <= sh[0] ? ST_TX : ST_RX_ADDR;
                        end else begin
                           st <= ST_IGNORE;
                        end
                     end else if (busy) begin
                        st <= ST_IGNORE;
                     end else begin
                        ack_drv <= 1'b1;
                        st      <= ST_ACK;
                        nxt     <= ST_RX_DATA;
                        if (st == ST_RX_DATA) begin
                           wr_valid <= 1'b1;
                           wr_addr  <= ptr;
                           wr_data  <= sh;
                           wr_seen  <= 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     ack_drv <= 1'b0;
                     cnt     <= '0;
                     if (tx_load) begin
                        sh     <= rd_data;
                        tx_drv <= ~rd_data[BYTE_W-1];
                        st     <= ST_TX;
                     end else begin
                        st <= nxt;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + CNT_W'(1);
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        tx_drv <= 1'b0;
                        mack   <= 1'b0;
                        st     <= ST_RD_ACK;
                     end else begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        tx_drv <= ~sh[BYTE_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (tx_load) begin
                        sh     <= rd_data;
                        tx_drv <= ~rd_data[BYTE_W-1];
                        cnt    <= '0;
                        st     <= ST_TX;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
   import tw_eeprom_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              busy_in,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              commit_pulse
);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("tw_eeprom_slave: ADDR_W must lie in 1..8");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("tw_eeprom_slave: PAGE_W must be at least 1");
      end
   endgenerate

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              ack_drv;
   logic              tx_drv;
   logic              ptr_load;
   logic [ADDR_W-1:0] ptr_load_val;
   logic              ptr_page_inc;
   logic              ptr_lin_inc;
   logic [ADDR_W-1:0] ptr;
   link_st_e          st;

   tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_in),
      .sda_raw   (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .page_inc (ptr_page_inc),
      .lin_inc  (ptr_lin_inc),
      .ptr      (ptr)
   );

   tw_link_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_det    (start_det),
      .stop_det     (stop_det),
      .sda_s        (sda_s),
      .busy         (busy_in),
      .ptr          (ptr),
      .rd_data      (rd_data),
      .ack_drv      (ack_drv),
      .tx_drv       (tx_drv),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .ptr_page_inc (ptr_page_inc),
      .ptr_lin_inc  (ptr_lin_inc),
      .wr_valid     (wr_valid),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .commit_pulse (commit_pulse),
      .st           (st)
   );

   assign sda_oe  = ack_drv | tx_drv;
   assign rd_addr = ptr;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
   import tw_eeprom_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     busy_in,
   input logic     sda_oe,
   input logic     wr_valid,
   input logic     commit_pulse,
   input logic     ack_drv,
   input logic     tx_drv,
   input logic     start_det,
   input logic     stop_det,
   input link_st_e st
);

   AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drv) |-> !$past(busy_in)); // R4

   AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ack_drv); // R5

   AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |=> !commit_pulse); // R7

   AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> $past(stop_det)); // R7

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R1

   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe); // R1

   AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_oe); // R3

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_drv && tx_drv)); // R8

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_in      (busy_in),
   .sda_oe       (sda_oe),
   .wr_valid     (wr_valid),
   .commit_pulse (commit_pulse),
   .ack_drv      (ack_drv),
   .tx_drv       (tx_drv),
   .start_det    (start_det),
   .stop_det     (stop_det),
   .st           (st)
);

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;

   localparam int Q        = 8;
   localparam int BUSY_CYC = 600;
   localparam int NVEC     = 5;
   // each entry: addressing byte (write), word address, data
   localparam logic [23:0] VEC [NVEC] = '{
      {8'hA0, 8'h03, 8'h11},
      {8'hAE, 8'h7F, 8'hA5},
      {8'hA6, 8'h80, 8'hFF},
      {8'hA2, 8'hC5, 8'h00},
      {8'hAA, 8'h55, 8'h77}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_in;
   logic       sda_oe;
   logic       busy_in;
   logic [7:0] rd_addr;
   logic [7:0] rd_data;
   logic       wr_valid;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic       commit_pulse;

   logic [7:0] mem [256];
   logic [7:0] wr_log [16];
   int         wr_cnt = 0;
   int         commit_cnt = 0;
   int         busy_cnt = 0;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   assign sda_in  = sda_m & ~sda_oe;
   assign rd_data = mem[rd_addr];
   assign busy_in = (busy_cnt != 0);

   tw_eeprom_slave u_tw_eeprom_slave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (scl_m),
      .sda_in       (sda_in),
      .sda_oe       (sda_oe),
      .busy_in      (busy_in),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .wr_valid     (wr_valid),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .commit_pulse (commit_pulse)
   );

   // model of the page-buffer / commit block
   always @(posedge clk) begin
      if (wr_valid) begin
         mem[wr_addr]          <= wr_data;
         wr_log[wr_cnt & 15]   <= wr_addr;
         wr_cnt                <= wr_cnt + 1;
      end
      if (commit_pulse) begin
         busy_cnt   <= BUSY_CYC;
         commit_cnt <= commit_cnt + 1;
      end else if (busy_cnt > 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic r);
      sda_m = b;
      hold();
      scl_m = 1'b1;
      hold();
      r = sda_in;
      hold();
      scl_m = 1'b0;
      hold();
   endtask

   task automatic start_c();
      sda_m = 1'b1;
      hold();
      scl_m = 1'b1;
      hold();
      sda_m = 1'b0;
      hold();
      scl_m = 1'b0;
      hold();
   endtask

   task automatic stop_c();
      sda_m = 1'b0;
      hold();
      scl_m = 1'b1;
      hold();
      sda_m = 1'b1;
      hold();
      hold();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
      bus_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, r);
         b[i] = r;
      end
      bus_bit(~mack, r);
   endtask

   task automatic wait_idle();
      while (busy_in) @(negedge clk);
      hold();
   endtask

   // write address then repeated start and read; leaves the transfer open
   task automatic open_random_read(input logic [7:0] addr, input string tag);
      logic a;
      start_c();
      send_byte(8'hA0, a);
      chk({tag, " ctrl ack"}, a, 1'b1);
      send_byte(addr, a);
      chk({tag, " addr ack"}, a, 1'b1);
      start_c();
      send_byte(8'hA1, a);
      chk({tag, " read ctrl ack"}, a, 1'b1);
   endtask

   logic [7:0] got;
   logic       ak;
   logic       rb;
   int         base;
   int         cbase;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      hold();

      // R12 reset state
      chk("R12 sda_oe", sda_oe, 1'b0);
      chk("R12 wr_valid", wr_valid, 1'b0);
      chk("R12 commit_pulse", commit_pulse, 1'b0);
      chk("R12 pointer", rd_addr, 8'h00);

      // R10 / R12 current-address read from reset pointer, R9 NACK release
      start_c();
      send_byte(8'hA1, ak);
      chk("R8 read ctrl ack", ak, 1'b1);
      recv_byte(got, 1'b0);
      chk("R12 first current read", got, 8'h5A);
      bus_bit(1'b1, rb);
      chk("R9 line released after nack", rb, 1'b1);
      stop_c();

      // vector table: byte write then random read back
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] c, ad, dt;
         {c, ad, dt} = VEC[v];
         cbase = commit_cnt;
         start_c();
         send_byte(c, ak);
         chk("R2 write ctrl ack", ak, 1'b1);
         send_byte(ad, ak);
         chk("R5 word addr ack", ak, 1'b1);
         send_byte(dt, ak);
         chk("R5 data ack", ak, 1'b1);
         chk("R5 strobe addr", wr_log[(wr_cnt - 1) & 15], ad);
         stop_c();
         chk("R7 commit once", commit_cnt, cbase + 1);
         if (v == 0) begin
            // R4 acknowledge polling while programming
            start_c();
            send_byte(8'hA0, ak);
            chk("R4 no ack while busy", ak, 1'b0);
            stop_c();
         end
         wait_idle();
         cbase = commit_cnt;
         open_random_read(ad, "R10");
         recv_byte(got, 1'b0);
         stop_c();
         chk("R10 random read data", got, dt);
         chk("R7 no commit after read", commit_cnt, cbase);
      end

      // R10 current-address read after access to 0x55 returns 0x56
      start_c();
      send_byte(8'hA1, ak);
      recv_byte(got, 1'b0);
      stop_c();
      chk("R10 current read n+1", got, 8'h56 ^ 8'h5A);

      // R6 page write of 10 bytes starting at 0x1E
      base = wr_cnt;
      start_c();
      send_byte(8'hA0, ak);
      send_byte(8'h1E, ak);
      for (int i = 0; i < 10; i++) begin
         send_byte(8'h40 + 8'(i), ak);
         chk("R6 page data ack", ak, 1'b1);
      end
      stop_c();
      chk("R6 strobe count", wr_cnt, base + 10);
      chk("R6 third addr wraps", wr_log[(base + 2) & 15], 8'h18);
      chk("R6 ninth addr overwrites", wr_log[(base + 8) & 15], 8'h1E);
      wait_idle();
      start_c();
      send_byte(8'hA1, ak);
      recv_byte(got, 1'b0);
      stop_c();
      chk("R6 pointer stays in page", got, 8'h42);
      open_random_read(8'h18, "R6");
      for (int i = 0; i < 8; i++) begin
         recv_byte(got, i != 7);
         chk("R6 page content", got, 8'h42 + 8'(i));
      end
      stop_c();

      // R1 start in the middle of a byte restarts reception
      start_c();
      bus_bit(1'b1, rb);
      bus_bit(1'b0, rb);
      bus_bit(1'b1, rb);
      bus_bit(1'b0, rb);
      start_c();
      send_byte(8'hA1, ak);
      chk("R1 ack after aborted byte", ak, 1'b1);
      recv_byte(got, 1'b0);
      stop_c();
      chk("R1 read after abort", got, 8'h20 ^ 8'h5A);

      // R3 foreign device code
      base  = wr_cnt;
      cbase = commit_cnt;
      start_c();
      send_byte(8'h50, ak);
      chk("R3 foreign ctrl nack", ak, 1'b0);
      send_byte(8'h00, ak);
      chk("R3 following byte nack", ak, 1'b0);
      send_byte(8'hFF, ak);
      chk("R3 third byte nack", ak, 1'b0);
      stop_c();
      chk("R3 no strobe", wr_cnt, base);
      chk("R3 no commit", commit_cnt, cbase);

      // R11 sequential read across 255 -> 0
      open_random_read(8'hFE, "R11");
      recv_byte(got, 1'b1);
      chk("R11 byte FE", got, 8'hA4);
      recv_byte(got, 1'b1);
      chk("R11 byte FF", got, 8'hA5);
      recv_byte(got, 1'b1);
      chk("R11 byte 00", got, 8'h5A);
      recv_byte(got, 1'b0);
      chk("R11 byte 01", got, 8'h5B);
      stop_c();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule